// File: doc/BRIEF.md
# Single-Shot Buffer DMA Engine

This block moves one block of data between host memory and a private 4096-byte buffer. Software programs a source address, a destination address and a byte count through a register port that accepts 32-bit and 64-bit accesses. It then writes a command word that starts the engine, selects the direction and optionally asks for a completion interrupt. After a programmable wait, the engine moves the data one 32-bit word at a time over a plain request/acknowledge memory master port. When it finishes, it clears its run flag.

The buffer occupies the byte window starting at 0x40000. The buffer-side address of a transfer must lie wholly inside that window. If it does not, the engine moves nothing and records a sticky error. The host-side address is trimmed to a configurable number of low bits, and a one-cycle event reports whenever the trimming removed set bits. Completion is announced as a one-cycle pulse on bit 8 of a raise vector, which a neighbouring interrupt-pending register decodes.

Top module: `dma_xfer_top`

## Requirements
- R1: Source, destination, count and command registers sit at offsets 0x80, 0x88, 0x90 and 0x98. Only access sizes of 4 and 8 bytes are honoured. A 4-byte write zero-extends into the 64-bit register, and a 4-byte read returns the low 32 bits zero-extended. Writes of any other size are ignored. Reads of any other size, or of an unmapped offset, return all ones. All registers read zero after reset.
- R2: In the command word, bit 0 is run, bit 1 is direction (0: host to buffer, 1: buffer to host) and bit 2 is interrupt enable. A command write with bit 0 clear is ignored and starts nothing.
- R3: While run is set, writes to all four registers are ignored, and reads still return their contents.
- R4: For a delay value d on `delay_cycles`, captured by an accepted command write at clock edge E0, `mem_req` first goes high after edge E(d+1).
- R5: The buffer-side address a is the destination for direction 0 and the source for direction 1. A transfer proceeds only when 0x40000 <= a, the count is nonzero and a + count <= 0x41000. It then uses byte offset a − 0x40000, so the window's last byte is reachable.
- R6: A violation of R5 issues no memory request and raises no interrupt. It clears run and sets sticky error bit 31 of the command read value. The next accepted command write clears the error.
- R7: The host-side address is ANDed with 2^MASK_BITS − 1 (default 28 bits). When that removes any set bit, `clamp_evt` is high for exactly one cycle as the transfer begins.
- R8: The count is in bytes, and data moves one 32-bit word per handshake at addresses rising by 4. `mem_be` bit k enables byte k (address +k). Every word has all four enables set, except that the final word of a count that is not a multiple of 4 enables only its low (count mod 4) bytes.
- R9: Once raised, `mem_req` stays high with `mem_addr`, `mem_we`, `mem_be` and `mem_wdata` unchanged until `mem_ack` is seen high on a clock edge.
- R10: When the final word is acknowledged, run clears. If bit 2 was set, `irq_raise` bit 8 is high for exactly one cycle. No other bit of `irq_raise` is ever set.
- R11: Data copied host to buffer and then buffer to host arrives unchanged for every byte below the count, including a block ending at the window's last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_size | input | 4 | Access size in bytes |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr/reg_size (combinational) |
| delay_cycles | input | DELAY_W | Start delay, sampled on an accepted command write |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1: write to host memory, 0: read |
| mem_addr | output | 64 | Host byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| clamp_evt | output | 1 | Host address lost bits to the mask |
| irq_raise | output | 32 | Interrupt raise pulses (bit 8: transfer done) |

## Verification
A table of round trips is the main stimulus. Each row copies a patterned host region into the buffer and back out to a second host region. The rows vary count (1, 4, 7, 16, 30, 64 bytes), buffer offset (one block ends at the window's last byte), start delay and interrupt enable. Comparing every byte below the count shows that both directions and the offset arithmetic are right. Checking the four bytes beyond the count shows whether the byte enables spare the tail of a partial word. The interrupt pulse count separates rows with and without completion requests. Directed cases then probe the three ways a buffer range can be illegal, an address carrying high bits, writes made while running, a command without run, odd access sizes, and the exact cycle the first request appears.

// File: rtl/dma_xfer_pkg.sv
// Package: shared constants, state type and the byte-enable helper
// for the single-shot buffer DMA engine.
package dma_xfer_pkg;

    localparam int REG_AW = 8;

    // Register offsets; software decodes these.
    localparam logic [REG_AW-1:0] OFS_SRC = 8'h80;
    localparam logic [REG_AW-1:0] OFS_DST = 8'h88;
    localparam logic [REG_AW-1:0] OFS_CNT = 8'h90;
    localparam logic [REG_AW-1:0] OFS_CMD = 8'h98;

    // Command word bit positions.
    localparam int CMD_RUN = 0;
    localparam int CMD_DIR = 1;
    localparam int CMD_IRQ = 2;
    localparam int CMD_ERR = 31;

    // Bit of the raise vector that the pending register maps to "done".
    localparam int IRQ_DONE_BIT = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_XFER
    } xfer_state_e;

    // Byte enables for a word: all four when at least a full word
    // remains, otherwise the low 'tail' bytes.
    function automatic logic [3:0] word_be(input logic full, input logic [1:0] tail);
        logic [3:0] be;
        if (full) begin
            be = 4'hF;
        end else begin
            case (tail)
                2'd1:    be = 4'h1;
                2'd2:    be = 4'h3;
                2'd3:    be = 4'h7;
                default: be = 4'hF;
            endcase
        end
        return be;
    endfunction

endpackage

// File: rtl/dma_xfer_lbuf.sv
// Module: local word buffer with byte-lane write enables.
// Assumes one access port shared by the sequencer: the read is
// combinational on the index and the write lands on the clock edge.
// Contents are not reset; software never reads unwritten bytes.
module dma_xfer_lbuf #(
    parameter int BUF_BYTES = 4096,
    localparam int WORDS = BUF_BYTES / 4,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [3:0]       be,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata
);

    logic [31:0] mem [WORDS];
    logic [31:0] lane_mask;

    // Expand each byte enable over its eight data bits.
    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign lane_mask[8*g +: 8] = {8{be[g]}};
    end

    // Merge enabled bytes into the addressed word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[idx] <= (mem[idx] & ~lane_mask) | (wdata & lane_mask);
        end
    end

    // Present the addressed word.
    assign rdata = mem[idx];

endmodule

// File: rtl/dma_xfer_regs.sv
// Module: register file of the DMA engine.
// Holds source, destination, count and command, decodes the register
// port and gates writes while a transfer runs. The sequencer reports
// completion and abort; they never coincide with an accepted write,
// because writes are refused while run is set.
module dma_xfer_regs
    import dma_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [3:0]        reg_size,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    input  logic              xfer_done,
    input  logic              xfer_abort,
    output logic [63:0]       src_o,
    output logic [63:0]       dst_o,
    output logic [63:0]       cnt_o,
    output logic              dir_o,
    output logic              irq_en_o,
    output logic              run_o,
    output logic              launch_o
);

    logic [63:0] src_q, dst_q, cnt_q;
    logic [2:0]  cmd_q;
    logic        err_q;
    logic        size_ok, wr_ok;
    logic [63:0] wval, rraw, cmd_view;

    // Qualify the access size and zero-extend narrow writes.
    always_comb begin
        size_ok = (reg_size == 4'd4) || (reg_size == 4'd8);
        wval    = (reg_size == 4'd4) ? {32'h0, reg_wdata[31:0]} : reg_wdata;
        wr_ok   = reg_wr && size_ok && !cmd_q[CMD_RUN];
    end

    assign launch_o = wr_ok && (reg_addr == OFS_CMD) && wval[CMD_RUN];

    // Register updates: accepted writes, then sequencer outcomes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
            cmd_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (wr_ok) begin
                case (reg_addr)
                    OFS_SRC: src_q <= wval;
                    OFS_DST: dst_q <= wval;
                    OFS_CNT: cnt_q <= wval;
                    OFS_CMD: begin
                        if (wval[CMD_RUN]) begin
                            cmd_q <= wval[2:0];
                            err_q <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
            if (xfer_done) begin
                cmd_q[CMD_RUN] <= 1'b0;
            end
            if (xfer_abort) begin
                cmd_q[CMD_RUN] <= 1'b0;
                err_q          <= 1'b1;
            end
        end
    end

    // Read mux: unmapped offsets and bad sizes read all ones.
    always_comb begin
        cmd_view          = '0;
        cmd_view[2:0]     = cmd_q;
        cmd_view[CMD_ERR] = err_q;
        case (reg_addr)
            OFS_SRC: rraw = src_q;
            OFS_DST: rraw = dst_q;
            OFS_CNT: rraw = cnt_q;
            OFS_CMD: rraw = cmd_view;
            default: rraw = '1;
        endcase
        if (!size_ok) begin
            reg_rdata = '1;
        end else if (reg_size == 4'd4) begin
            reg_rdata = {32'h0, rraw[31:0]};
        end else begin
            reg_rdata = rraw;
        end
    end

    assign src_o    = src_q;
    assign dst_o    = dst_q;
    assign cnt_o    = cnt_q;
    assign dir_o    = cmd_q[CMD_DIR];
    assign irq_en_o = cmd_q[CMD_IRQ];
    assign run_o    = cmd_q[CMD_RUN];

    // R3: programmed values hold while a transfer is in flight.
    p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q[CMD_RUN] |=> $stable(src_q) && $stable(dst_q) && $stable(cnt_q))
        else $error("p_frozen_r3");

    // R10: completion drops run.
    p_done_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !cmd_q[CMD_RUN])
        else $error("p_done_clears_r10");

    // R6: an abort leaves the error flag set and run clear.
    p_abort_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_abort |=> err_q && !cmd_q[CMD_RUN])
        else $error("p_abort_err_r6");

endmodule

// File: rtl/dma_xfer_seq.sv
// Module: transfer sequencer of the DMA engine.
// Counts down the start delay, checks the buffer range, masks the
// host address, then moves one word per request/acknowledge handshake.
// Assumes the register file keeps its outputs stable while run is set
// and that addresses are word aligned (low two bits are not used to
// place data).
module dma_xfer_seq
    import dma_xfer_pkg::*;
#(
    parameter int          BUF_BYTES = 4096,
    parameter logic [63:0] BUF_BASE  = 64'h40000,
    parameter int          MASK_BITS = 28,
    parameter int          DELAY_W   = 8,
    localparam int         IDX_W     = $clog2(BUF_BYTES / 4),
    localparam int         CNT_W     = $clog2(BUF_BYTES) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic [63:0]        src,
    input  logic [63:0]        dst,
    input  logic [63:0]        cnt,
    input  logic               dir,
    input  logic               irq_en,
    input  logic [DELAY_W-1:0] delay_cycles,
    output logic               done_o,
    output logic               abort_o,
    output logic               clamp_o,
    output logic [31:0]        irq_raise_o,
    output logic               mem_req,
    output logic               mem_we,
    output logic [63:0]        mem_addr,
    output logic [31:0]        mem_wdata,
    output logic [3:0]         mem_be,
    input  logic               mem_ack,
    input  logic [31:0]        mem_rdata,
    output logic               buf_wr_en,
    output logic [IDX_W-1:0]   buf_idx,
    output logic [3:0]         buf_be,
    output logic [31:0]        buf_wdata,
    input  logic [31:0]        buf_rdata
);

    localparam logic [63:0] HOST_MASK = (64'd1 << MASK_BITS) - 64'd1;
    localparam logic [64:0] BUF_LIM   = {1'b0, BUF_BASE} + 65'(BUF_BYTES);

    xfer_state_e        state_q;
    logic [DELAY_W-1:0] dcnt_q;
    logic [63:0]        hptr_q;
    logic [IDX_W-1:0]   bidx_q;
    logic [CNT_W-1:0]   rem_q;
    logic               clamp_q, irq_q;

    logic [63:0] buf_a, host_a, host_m;
    logic [64:0] buf_end;
    logic        in_range, clamp_hit, fire, beat, last_word;

    // Range check and host-address masking for the pending transfer.
    always_comb begin
        buf_a     = dir ? src : dst;
        host_a    = dir ? dst : src;
        host_m    = host_a & HOST_MASK;
        clamp_hit = (host_m != host_a);
        buf_end   = {1'b0, buf_a} + {1'b0, cnt};
        in_range  = (buf_a >= BUF_BASE) && (cnt != 64'd0) && (buf_end <= BUF_LIM);
    end

    // Launch decision and per-word handshake events.
    always_comb begin
        fire      = (state_q == ST_WAIT) && (dcnt_q == '0);
        abort_o   = fire && !in_range;
        beat      = (state_q == ST_XFER) && mem_ack;
        last_word = (rem_q <= CNT_W'(4));
        done_o    = beat && last_word;
    end

    // Memory master and buffer port drive.
    always_comb begin
        mem_req   = (state_q == ST_XFER);
        mem_we    = dir;
        mem_addr  = hptr_q;
        mem_wdata = buf_rdata;
        mem_be    = word_be(rem_q >= CNT_W'(4), rem_q[1:0]);
        buf_wr_en = beat && !dir;
        buf_idx   = bidx_q;
        buf_be    = mem_be;
        buf_wdata = mem_rdata;
    end

    // Sequencer state, pointers and remaining byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dcnt_q  <= '0;
            hptr_q  <= '0;
            bidx_q  <= '0;
            rem_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (launch) begin
                        dcnt_q  <= delay_cycles;
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (dcnt_q != '0) begin
                        dcnt_q <= dcnt_q - DELAY_W'(1);
                    end else if (in_range) begin
                        hptr_q  <= host_m & ~64'd3;
                        bidx_q  <= IDX_W'((buf_a - BUF_BASE) >> 2);
                        rem_q   <= cnt[CNT_W-1:0];
                        state_q <= ST_XFER;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_XFER: begin
                    if (mem_ack) begin
                        hptr_q <= hptr_q + 64'd4;
                        bidx_q <= bidx_q + IDX_W'(1);
                        rem_q  <= rem_q - CNT_W'(4);
                        if (last_word) begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // One-cycle clamp and completion-interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clamp_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            clamp_q <= fire && in_range && clamp_hit;
            irq_q   <= done_o && irq_en;
        end
    end

    // Place the done pulse on its bit of the raise vector.
    always_comb begin
        irq_raise_o               = '0;
        irq_raise_o[IRQ_DONE_BIT] = irq_q;
    end

    assign clamp_o = clamp_q;

    // R9: an unacknowledged request holds with stable payload.
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_be)
                                && $stable(mem_we) && $stable(mem_wdata))
        else $error("p_req_hold_r9");

    // R8: every request enables at least one byte.
    p_be_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_be != 4'h0)
        else $error("p_be_live_r8");

    // R6: an aborted launch issues no request.
    p_abort_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !mem_req)
        else $error("p_abort_quiet_r6");

    // R10: at most one raise bit is ever active.
    p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_raise_o))
        else $error("p_irq_single_r10");

endmodule

// File: rtl/dma_xfer_top.sv
// Module: single-shot buffer DMA engine top level.
// Connects the register file, the transfer sequencer and the local
// buffer. Assumes the host memory answers each request with mem_ack
// and, for reads, valid mem_rdata in the acknowledge cycle.
module dma_xfer_top
    import dma_xfer_pkg::*;
#(
    parameter int          BUF_BYTES = 4096,
    parameter logic [63:0] BUF_BASE  = 64'h40000,
    parameter int          MASK_BITS = 28,
    parameter int          DELAY_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [7:0]         reg_addr,
    input  logic [3:0]         reg_size,
    input  logic [63:0]        reg_wdata,
    output logic [63:0]        reg_rdata,
    input  logic [DELAY_W-1:0] delay_cycles,
    output logic               mem_req,
    output logic               mem_we,
    output logic [63:0]        mem_addr,
    output logic [31:0]        mem_wdata,
    output logic [3:0]         mem_be,
    input  logic               mem_ack,
    input  logic [31:0]        mem_rdata,
    output logic               clamp_evt,
    output logic [31:0]        irq_raise
);

    localparam int IDX_W = $clog2(BUF_BYTES / 4);

    logic [63:0]      src, dst, cnt;
    logic             dir, irq_en, run, launch, done, abort;
    logic             buf_wr_en;
    logic [IDX_W-1:0] buf_idx;
    logic [3:0]       buf_be;
    logic [31:0]      buf_wdata, buf_rdata;

    dma_xfer_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_size   (reg_size),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .xfer_done  (done),
        .xfer_abort (abort),
        .src_o      (src),
        .dst_o      (dst),
        .cnt_o      (cnt),
        .dir_o      (dir),
        .irq_en_o   (irq_en),
        .run_o      (run),
        .launch_o   (launch)
    );

    dma_xfer_seq #(
        .BUF_BYTES (BUF_BYTES),
        .BUF_BASE  (BUF_BASE),
        .MASK_BITS (MASK_BITS),
        .DELAY_W   (DELAY_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch       (launch),
        .src          (src),
        .dst          (dst),
        .cnt          (cnt),
        .dir          (dir),
        .irq_en       (irq_en),
        .delay_cycles (delay_cycles),
        .done_o       (done),
        .abort_o      (abort),
        .clamp_o      (clamp_evt),
        .irq_raise_o  (irq_raise),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_be       (mem_be),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .buf_wr_en    (buf_wr_en),
        .buf_idx      (buf_idx),
        .buf_be       (buf_be),
        .buf_wdata    (buf_wdata),
        .buf_rdata    (buf_rdata)
    );

    dma_xfer_lbuf #(
        .BUF_BYTES (BUF_BYTES)
    ) u_lbuf (
        .clk   (clk),
        .wr_en (buf_wr_en),
        .idx   (buf_idx),
        .be    (buf_be),
        .wdata (buf_wdata),
        .rdata (buf_rdata)
    );

    // R2/R10: run only ever clears through done or abort while busy.
    p_run_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        run && !done && !abort |=> run)
        else $error("p_run_exit_r10");

endmodule

// File: tb/dma_xfer_top_tb_top.sv
// Bench: round-trip table, then directed cases for reset, ranges,
// clamping, freezing, access sizes and start delay.
module dma_xfer_top_tb_top;

    localparam logic [63:0] BASE = 64'h40000;
    localparam logic [7:0]  A_SRC = 8'h80;
    localparam logic [7:0]  A_DST = 8'h88;
    localparam logic [7:0]  A_CNT = 8'h90;
    localparam logic [7:0]  A_CMD = 8'h98;

    localparam int NROW = 6;
    localparam int R_CNT [NROW] = '{4, 7, 16, 1, 30, 64};
    localparam int R_OFF [NROW] = '{0, 8, 4080, 400, 12, 256};
    localparam int R_HS  [NROW] = '{'h000, 'h040, 'h080, 'h0C0, 'h100, 'h140};
    localparam int R_HD  [NROW] = '{'h200, 'h260, 'h2C0, 'h320, 'h380, 'h3B0};
    localparam int R_DLY [NROW] = '{0, 3, 1, 0, 2, 7};
    localparam int R_IRQ [NROW] = '{1, 0, 1, 1, 0, 1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [3:0]  reg_size = 4'd8;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [7:0]  delay_cycles = '0;
    logic        mem_req, mem_we;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        clamp_evt;
    logic [31:0] irq_raise;

    int n_checks = 0;
    int n_fail = 0;
    int n_irq = 0;
    int n_clamp = 0;
    int n_req = 0;
    int n_other_irq = 0;
    int n_bad_addr = 0;
    logic [63:0] last_addr = '0;
    logic [7:0] hmem [1024];

    dma_xfer_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_size     (reg_size),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .delay_cycles (delay_cycles),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_be       (mem_be),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .clamp_evt    (clamp_evt),
        .irq_raise    (irq_raise)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Host memory responder: acknowledges one cycle after a request.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (rst_n && mem_req) begin
                int a;
                if (mem_addr[63:10] != '0) n_bad_addr++;
                a = int'({mem_addr[9:2], 2'b00});
                if (mem_we) begin
                    for (int k = 0; k < 4; k++) begin
                        if (mem_be[k]) hmem[a + k] = mem_wdata[8*k +: 8];
                    end
                end else begin
                    mem_rdata = {hmem[a + 3], hmem[a + 2], hmem[a + 1], hmem[a]};
                end
                mem_ack = 1'b1;
            end
        end
    end

    // Event monitor: counts pulses and request cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (irq_raise[8]) n_irq++;
                if ((irq_raise & ~32'h100) != '0) n_other_irq++;
                if (clamp_evt) n_clamp++;
                if (mem_req) begin
                    n_req++;
                    last_addr = mem_addr;
                end
            end
        end
    end

    task automatic reg_write(input logic [7:0] a, input logic [3:0] sz, input logic [63:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_size  = sz;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, input logic [3:0] sz, output logic [63:0] d);
        reg_addr = a;
        reg_size = sz;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle(input string tag);
        logic [63:0] v;
        logic idle;
        idle = 1'b0;
        for (int i = 0; i < 5000 && !idle; i++) begin
            reg_read(A_CMD, 4'd8, v);
            if (!v[0]) idle = 1'b1;
            else @(negedge clk);
        end
        chk({tag, " run clears"}, {63'd0, idle}, 64'd1);
    endtask

    task automatic run_dma(input logic [63:0] s, input logic [63:0] d, input logic [63:0] c,
                           input logic [63:0] cmd, input int dly, input string tag);
        delay_cycles = 8'(dly);
        reg_write(A_SRC, 4'd8, s);
        reg_write(A_DST, 4'd8, d);
        reg_write(A_CNT, 4'd8, c);
        reg_write(A_CMD, 4'd8, cmd);
        wait_idle(tag);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] v;
        int irq0, req0, clamp0, bad;
        for (int i = 0; i < 1024; i++) hmem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R1).
        reg_read(A_SRC, 4'd8, v); chk("R1 reset src", v, 64'd0);
        reg_read(A_DST, 4'd8, v); chk("R1 reset dst", v, 64'd0);
        reg_read(A_CNT, 4'd8, v); chk("R1 reset cnt", v, 64'd0);
        reg_read(A_CMD, 4'd8, v); chk("R1 reset cmd", v, 64'd0);
        chk("R1 reset mem_req", {63'd0, mem_req}, 64'd0);
        chk("R10 reset irq_raise", {32'd0, irq_raise}, 64'd0);

        // Round-trip table (R11, R8, R10, R5 window end).
        for (int r = 0; r < NROW; r++) begin
            irq0 = n_irq;
            for (int i = 0; i < R_CNT[r] + 4; i++) hmem[R_HS[r] + i] = 8'((r * 37 + i * 11 + 5) & 255);
            for (int i = 0; i < R_CNT[r] + 8; i++) hmem[R_HD[r] + i] = 8'hEE;
            run_dma(64'(R_HS[r]), BASE + 64'(R_OFF[r]), 64'(R_CNT[r]),
                    64'(1 + 4 * R_IRQ[r]), R_DLY[r], "R2 host-to-buffer");
            run_dma(BASE + 64'(R_OFF[r]), 64'(R_HD[r]), 64'(R_CNT[r]),
                    64'(3 + 4 * R_IRQ[r]), R_DLY[r], "R2 buffer-to-host");
            bad = 0;
            for (int i = 0; i < R_CNT[r]; i++) begin
                if (hmem[R_HD[r] + i] !== 8'((r * 37 + i * 11 + 5) & 255)) bad++;
            end
            chk($sformatf("R11 row %0d mismatching bytes", r), 64'(bad), 64'd0);
            bad = 0;
            for (int i = R_CNT[r]; i < R_CNT[r] + 4; i++) begin
                if (hmem[R_HD[r] + i] !== 8'hEE) bad++;
            end
            chk($sformatf("R8 row %0d bytes past count touched", r), 64'(bad), 64'd0);
            chk($sformatf("R10 row %0d irq pulses", r), 64'(n_irq - irq0), 64'(2 * R_IRQ[r]));
            reg_read(A_CMD, 4'd8, v);
            chk($sformatf("R10 row %0d cmd after done", r), v, 64'(2 + 4 * R_IRQ[r]));
        end
        chk("R7 no clamp for in-mask addresses", 64'(n_clamp), 64'd0);

        // Bounds violations (R5, R6).
        irq0 = n_irq; req0 = n_req;
        run_dma(64'h0, BASE - 64'd4, 64'd4, 64'd5, 0, "R6 below window");
        reg_read(A_CMD, 4'd8, v); chk("R6 below window err", v, 64'h8000_0004);
        run_dma(64'h0, BASE, 64'd0, 64'd5, 0, "R6 zero count");
        reg_read(A_CMD, 4'd8, v); chk("R6 zero count err", v, 64'h8000_0004);
        run_dma(64'h0, BASE + 64'd4092, 64'd5, 64'd5, 1, "R5 past window end");
        reg_read(A_CMD, 4'd8, v); chk("R5 past window end err", v, 64'h8000_0004);
        chk("R6 no requests on abort", 64'(n_req - req0), 64'd0);
        chk("R6 no irq on abort", 64'(n_irq - irq0), 64'd0);
        run_dma(64'h0, BASE + 64'd4092, 64'd4, 64'd1, 0, "R5 last word");
        reg_read(A_CMD, 4'd8, v); chk("R6 err cleared by new command", v, 64'd0);

        // Host address clamping (R7).
        clamp0 = n_clamp;
        run_dma(64'hFFFF_FFF0_0000_0040, BASE, 64'd4, 64'd1, 0, "R7 clamp");
        chk("R7 clamp pulse count", 64'(n_clamp - clamp0), 64'd1);
        chk("R7 masked address", last_addr, 64'h40);

        // Command without run is ignored (R2).
        req0 = n_req;
        reg_write(A_CMD, 4'd8, 64'h6);
        repeat (20) @(negedge clk);
        reg_read(A_CMD, 4'd8, v); chk("R2 cmd without run ignored", v, 64'd0);
        chk("R2 no request without run", 64'(n_req - req0), 64'd0);

        // Frozen registers while running (R3).
        delay_cycles = 8'd60;
        reg_write(A_SRC, 4'd8, 64'h0);
        reg_write(A_DST, 4'd8, BASE);
        reg_write(A_CNT, 4'd8, 64'd4);
        reg_write(A_CMD, 4'd8, 64'd1);
        reg_write(A_SRC, 4'd8, 64'h123);
        reg_write(A_CNT, 4'd8, 64'd0);
        reg_read(A_SRC, 4'd8, v); chk("R3 src write ignored while running", v, 64'h0);
        reg_read(A_CMD, 4'd8, v); chk("R3 cmd readable while running", v, 64'd1);
        wait_idle("R3 frozen");
        reg_read(A_CMD, 4'd8, v); chk("R3 count write ignored (no abort)", v, 64'd0);

        // Access sizes (R1).
        reg_write(A_SRC, 4'd8, 64'hAAAA_BBBB_CCCC_DDDD);
        reg_read(A_SRC, 4'd8, v); chk("R1 64-bit write", v, 64'hAAAA_BBBB_CCCC_DDDD);
        reg_read(A_SRC, 4'd4, v); chk("R1 32-bit read", v, 64'hCCCC_DDDD);
        reg_write(A_SRC, 4'd4, 64'hFFFF_0000_0000_1234);
        reg_read(A_SRC, 4'd8, v); chk("R1 32-bit write zero-extends", v, 64'h1234);
        reg_write(A_SRC, 4'd2, 64'h5555);
        reg_read(A_SRC, 4'd8, v); chk("R1 2-byte write ignored", v, 64'h1234);
        reg_read(A_SRC, 4'd1, v); chk("R1 1-byte read all ones", v, '1);
        reg_read(8'h00, 4'd8, v); chk("R1 unmapped read all ones", v, '1);

        // Start delay (R4).
        delay_cycles = 8'd5;
        reg_write(A_SRC, 4'd8, 64'h0);
        reg_write(A_DST, 4'd8, BASE);
        reg_write(A_CNT, 4'd8, 64'd4);
        reg_write(A_CMD, 4'd8, 64'd1);
        repeat (5) @(negedge clk);
        chk("R4 no request before delay", {63'd0, mem_req}, 64'd0);
        @(negedge clk);
        chk("R4 request after delay+1 edges", {63'd0, mem_req}, 64'd1);
        wait_idle("R4 delay");

        chk("R10 no other raise bits", 64'(n_other_irq), 64'd0);
        chk("R7 host addresses inside model", 64'(n_bad_addr), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule